// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage In-Order Pipeline

This block is the control companion of a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and writeback. Fetch hands it the valid bit and address of the instruction it currently holds. The controller keeps its own shadow copy of the valid bit, address and pending fault code for every later stage. Each of the first four stages can report a fault code for the instruction sitting in it. The controller folds those reports into one precise exception.

The first fault an instruction meets is latched into its shadow slot and travels with it. Once a fault is pending anywhere, the controller holds fetch and turns every younger instruction into a bubble. Older instructions keep flowing and retire normally. The faulting instruction marches on without writing anything. When it arrives in writeback, the controller raises a redirect to a fixed handler address. It then records the instruction's own address and cause in the exception registers.

A mispredict flush from execute removes the two younger slots. Any fault those slots carried disappears with them.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the outputs are idle: stall_front_o, redirect_o, wb_commit_o and flush_o are all 0, and epc_o and ecause_o are 0.
- R2: An instruction presented in fetch in cycle t with no fault reaches writeback in cycle t+4. In that cycle wb_commit_o is 1 and wb_pc_o carries its address. Instructions retire in fetch order.
- R3: Fault codes are 0 none, 1 fetch page fault, 2 fetch TLB miss, 3 illegal opcode, 4 privilege violation, 5 overflow, 6 divide by zero, 7 data page fault, 8 data TLB miss, 9 protection violation. The first nonzero code an instruction meets is kept. A code reported for it in a later stage never replaces the kept code.
- R4: When several stages hold faulting instructions in the same cycle, the exception is taken for the instruction in the latest stage, which is the oldest in program order.
- R5: While any live instruction carries a fault, stall_front_o is 1. Flush bit k is 1 for every stage k younger than the oldest faulting stage. The flush bits are indexed 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback. In the redirect cycle all five flush bits are 1.
- R6: Every instruction older than the faulting one retires, and its memory write enable mem_wr_ok_o pulses once in the memory stage. The faulting instruction and all younger ones never assert wb_commit_o or mem_wr_ok_o.
- R7: redirect_o is 1 in the cycle after the last older instruction leaves writeback, which is the cycle the faulting instruction sits in writeback. In that cycle redirect_pc_o equals HANDLER_PC. From the next cycle, epc_o holds the faulting instruction's address and ecause_o holds its kept code. Both stay unchanged until the next redirect.
- R8: A fault on an instruction with nothing older in flight needs no drain. For an instruction fetched in cycle t, redirect_o is 1 in cycle t+4.
- R9: br_flush_i flushes the fetch and decode slots in the same cycle and discards their faults. No exception is taken for them.
- R10: A fault detected later on an older instruction overrides a fault detected earlier on a younger one. The exception reports the older instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid_i | input | 1 | Fetch stage holds an instruction |
| if_pc_i | input | PC_W | Address of the fetched instruction |
| if_cause_i | input | 4 | Fault code raised in fetch |
| id_cause_i | input | 4 | Fault code raised in decode |
| ex_cause_i | input | 4 | Fault code raised in execute |
| mem_cause_i | input | 4 | Fault code raised in memory |
| br_flush_i | input | 1 | Mispredict flush of the fetch and decode slots |
| stall_front_o | output | 1 | Hold fetch |
| flush_o | output | 5 | Per-stage bubble enable, bit 0 fetch to bit 4 writeback |
| mem_wr_ok_o | output | 1 | Memory-stage instruction may write memory |
| wb_commit_o | output | 1 | Writeback instruction may write registers |
| wb_pc_o | output | PC_W | Address of the writeback instruction |
| redirect_o | output | 1 | Jump to the exception handler |
| redirect_pc_o | output | PC_W | Handler address |
| epc_o | output | PC_W | Address of the last excepting instruction |
| ecause_o | output | 4 | Code of the last exception |

## Verification
Some properties hold on every cycle, and the assertions cover those. The redirect always carries the handler address, always stalls fetch and flushes every stage, and never coincides with a retirement. The exception registers load the writeback address and code exactly on a redirect and stay still otherwise. Every memory write is followed by a retirement.

Other behaviour depends on the injected fault pattern, and only the scoreboard scenarios can show it. This covers which instruction wins when faults pile up, which code is kept, and how many older instructions retire before the redirect. It also covers the exact redirect cycle and the disappearance of wrong-path faults after a mispredict.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NSTG  = 5;
  localparam int S_IF  = 0;
  localparam int S_ID  = 1;
  localparam int S_EX  = 2;
  localparam int S_MEM = 3;
  localparam int S_WB  = 4;

  typedef enum logic [3:0] {
    C_NONE    = 4'd0,
    C_IPAGE   = 4'd1,
    C_ITLB    = 4'd2,
    C_ILLEGAL = 4'd3,
    C_PRIV    = 4'd4,
    C_OVF     = 4'd5,
    C_DIVZ    = 4'd6,
    C_DPAGE   = 4'd7,
    C_DTLB    = 4'd8,
    C_PROT    = 4'd9
  } cause_e;

  // the code an instruction already carries outranks anything found later
  function automatic cause_e merge_cause(cause_e held, cause_e fresh);
    return (held != C_NONE) ? held : fresh;
  endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  cause_e          in_cause,
  input  logic            kill,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output cause_e          q_cause
);

  logic keep;
  assign keep = in_valid && !kill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_cause <= C_NONE;
    end else begin
      q_valid <= keep;
      q_pc    <= in_pc;
      q_cause <= keep ? in_cause : C_NONE;
    end
  end

endmodule

// File: rtl/exc_oldest_pick.sv
module exc_oldest_pick #(
  parameter int N = 5,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] flt,
  output logic         found,
  output logic [W-1:0] oldest
);

  // later stage = older instruction, so the highest set index wins
  always_comb begin
    found  = 1'b0;
    oldest = '0;
    for (int i = 0; i < N; i++) begin
      if (flt[i]) begin
        found  = 1'b1;
        oldest = W'(i);
      end
    end
  end

endmodule

// File: rtl/exc_retire.sv
module exc_retire
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [PC_W-1:0] wb_pc,
  input  cause_e          wb_cause,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] epc_q,
  output cause_e          cause_q
);

  assign redirect    = take;
  assign redirect_pc = HANDLER_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= C_NONE;
    end else if (take) begin
      epc_q   <= wb_pc;
      cause_q <= wb_cause;
    end
  end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid_i,
  input  logic [PC_W-1:0] if_pc_i,
  input  logic [3:0]      if_cause_i,
  input  logic [3:0]      id_cause_i,
  input  logic [3:0]      ex_cause_i,
  input  logic [3:0]      mem_cause_i,
  input  logic            br_flush_i,
  output logic            stall_front_o,
  output logic [NSTG-1:0] flush_o,
  output logic            mem_wr_ok_o,
  output logic            wb_commit_o,
  output logic [PC_W-1:0] wb_pc_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic [PC_W-1:0] epc_o,
  output logic [3:0]      ecause_o
);

  localparam int SW = $clog2(NSTG);

  logic [NSTG-1:0] st_valid;
  logic [NSTG-1:0] live;
  logic [NSTG-1:0] flt;
  logic [NSTG-1:0] br_kill;
  logic [NSTG-1:0] young_kill;
  logic [PC_W-1:0] st_pc   [NSTG];
  cause_e          st_held [NSTG];
  cause_e          st_new  [NSTG];
  cause_e          st_eff  [NSTG];

  // named internal events used by the checker
  logic            found;
  logic [SW-1:0]   oldest;
  logic            take;
  cause_e          wb_cause;
  cause_e          cause_q;

  // fetch slot comes straight from the ports
  assign st_valid[S_IF] = if_valid_i;
  assign st_pc[S_IF]    = if_pc_i;
  assign st_held[S_IF]  = C_NONE;

  // fresh fault reports per stage; writeback cannot raise one
  assign st_new[S_IF]  = cause_e'(if_cause_i);
  assign st_new[S_ID]  = cause_e'(id_cause_i);
  assign st_new[S_EX]  = cause_e'(ex_cause_i);
  assign st_new[S_MEM] = cause_e'(mem_cause_i);
  assign st_new[S_WB]  = C_NONE;

  generate
    for (genvar k = 0; k < NSTG; k++) begin : g_slot
      assign br_kill[k]    = br_flush_i && (k <= S_ID);
      assign live[k]       = st_valid[k] && !br_kill[k];
      assign st_eff[k]     = merge_cause(st_held[k], st_new[k]);
      assign flt[k]        = live[k] && (st_eff[k] != C_NONE);
      assign young_kill[k] = found && (SW'(k) < oldest);
    end

    for (genvar k = 1; k < NSTG; k++) begin : g_reg
      exc_stage_reg #(.PC_W(PC_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (live[k-1]),
        .in_pc    (st_pc[k-1]),
        .in_cause (st_eff[k-1]),
        .kill     (young_kill[k-1]),
        .q_valid  (st_valid[k]),
        .q_pc     (st_pc[k]),
        .q_cause  (st_held[k])
      );
    end
  endgenerate

  exc_oldest_pick #(.N(NSTG)) u_pick (
    .flt    (flt),
    .found  (found),
    .oldest (oldest)
  );

  // the faulting instruction reaches writeback only after every older one left
  assign take     = flt[S_WB];
  assign wb_cause = st_held[S_WB];

  assign stall_front_o = found;
  assign flush_o       = br_kill | young_kill | {take, {(NSTG-1){1'b0}}};
  assign mem_wr_ok_o   = live[S_MEM] && (st_eff[S_MEM] == C_NONE) && !young_kill[S_MEM];
  assign wb_commit_o   = st_valid[S_WB] && (st_held[S_WB] == C_NONE);
  assign wb_pc_o       = st_pc[S_WB];

  exc_retire #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_retire (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .wb_pc       (st_pc[S_WB]),
    .wb_cause    (wb_cause),
    .redirect    (redirect_o),
    .redirect_pc (redirect_pc_o),
    .epc_q       (epc_o),
    .cause_q     (cause_q)
  );

  assign ecause_o = cause_q;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall_front_o,
  input logic [4:0]      flush_o,
  input logic            mem_wr_ok_o,
  input logic            wb_commit_o,
  input logic [PC_W-1:0] wb_pc_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o,
  input logic [PC_W-1:0] epc_o,
  input logic [3:0]      ecause_o,
  input logic [3:0]      wb_cause
);

  // R7
  handler_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> redirect_pc_o == HANDLER_PC);

  // R6
  no_retire_on_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_commit_o, redirect_o}));

  // R5
  redirect_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> stall_front_o && (flush_o == 5'b11111));

  // R7
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (epc_o == $past(wb_pc_o)) && (ecause_o == $past(wb_cause)));

  // R7
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |=> $stable(epc_o) && $stable(ecause_o));

  // R6
  store_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok_o |=> wb_commit_o);

endmodule

bind exc_ctrl exc_ctrl_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall_front_o (stall_front_o),
  .flush_o       (flush_o),
  .mem_wr_ok_o   (mem_wr_ok_o),
  .wb_commit_o   (wb_commit_o),
  .wb_pc_o       (wb_pc_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .epc_o         (epc_o),
  .ecause_o      (ecause_o),
  .wb_cause      (wb_cause)
);

// File: tb/test_exc_ctrl.sv
`timescale 1ns/1ps
module test_exc_ctrl;

  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_valid_i = 1'b0;
  logic [31:0] if_pc_i = '0;
  logic [3:0]  if_cause_i = '0, id_cause_i = '0, ex_cause_i = '0, mem_cause_i = '0;
  logic        br_flush_i = 1'b0;
  logic        stall_front_o, mem_wr_ok_o, wb_commit_o, redirect_o;
  logic [4:0]  flush_o;
  logic [31:0] wb_pc_o, redirect_pc_o, epc_o;
  logic [3:0]  ecause_o;

  always #2.5 clk = ~clk;

  exc_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) i_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .if_valid_i(if_valid_i), .if_pc_i(if_pc_i),
    .if_cause_i(if_cause_i), .id_cause_i(id_cause_i), .ex_cause_i(ex_cause_i),
    .mem_cause_i(mem_cause_i), .br_flush_i(br_flush_i),
    .stall_front_o(stall_front_o), .flush_o(flush_o), .mem_wr_ok_o(mem_wr_ok_o),
    .wb_commit_o(wb_commit_o), .wb_pc_o(wb_pc_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .epc_o(epc_o), .ecause_o(ecause_o)
  );

  int n_checks = 0;
  int n_errors = 0;

  // scoreboard state
  logic [31:0] exp_q [$];
  bit          mon_on = 1'b0;
  int          cyc = 0;
  string       cur_tag = "";
  bit          exp_exc;
  logic [31:0] exp_epc;
  logic [3:0]  exp_cause;
  int          exp_rcyc;
  int          chk_cyc;
  logic [4:0]  chk_flush;
  bit          seen_exc;
  bit          epc_due;
  int          wr_cnt;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected retirements and checks exception events
  always @(negedge clk) begin
    if (mon_on) begin
      if (epc_due) begin
        epc_due = 1'b0;
        check(epc_o == exp_epc, {"R7 ", cur_tag}, "epc", epc_o, exp_epc);
        check(ecause_o == exp_cause, {"R3 ", cur_tag}, "cause", ecause_o, exp_cause);
      end
      if (mem_wr_ok_o) wr_cnt++;
      if (wb_commit_o) begin
        if (exp_q.size() == 0)
          check(1'b0, {"R6 ", cur_tag}, "unexpected retire pc", wb_pc_o, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(wb_pc_o == e, {"R2 ", cur_tag}, "retire pc", wb_pc_o, e);
        end
      end
      if (redirect_o) begin
        seen_exc = 1'b1;
        check(exp_exc, {"R9 ", cur_tag}, "unexpected redirect", 1, 0);
        check(cyc == exp_rcyc, {"R7 ", cur_tag}, "redirect cycle", cyc, exp_rcyc);
        check(redirect_pc_o == HANDLER, "R7", "handler pc", redirect_pc_o, HANDLER);
        epc_due = 1'b1;
      end
      if (cyc == chk_cyc) begin
        check(stall_front_o == 1'b1, "R5", "stall", stall_front_o, 1);
        check(flush_o == chk_flush, "R5", "flush mask", flush_o, chk_flush);
      end
    end
  end

  // driver: n instructions fetched back to back, up to two injected faults
  task automatic run_scn(input int sid, input int n,
                         input int fi0, input int fs0, input int fc0,
                         input int fi1, input int fs1, input int fc1,
                         input int brc, input string tag);
    logic [31:0] base;
    int j;
    int best_s;
    base = 32'h1000 * sid;
    cur_tag = tag;
    j = -1;
    for (int i = 0; i < n; i++) begin
      bit alive;
      bit hit;
      alive = !(brc >= 0 && (i == brc || i == brc - 1));
      hit = (fi0 == i) || (fi1 == i);
      if (alive && hit && j < 0) j = i;
    end
    exp_exc = (j >= 0);
    exp_rcyc = j + 4;
    exp_epc = base + 32'(4 * j);
    best_s = 99;
    exp_cause = 4'd0;
    if (fi0 == j && fs0 < best_s) begin best_s = fs0; exp_cause = 4'(fc0); end
    if (fi1 == j && fs1 < best_s) begin best_s = fs1; exp_cause = 4'(fc1); end
    for (int i = 0; i < n; i++) begin
      bit alive;
      alive = !(brc >= 0 && (i == brc || i == brc - 1));
      if (alive && (j < 0 || i < j)) exp_q.push_back(base + 32'(4 * i));
    end
    if (fi0 >= 0 && fi1 < 0 && brc < 0) begin
      chk_cyc = fi0 + fs0;
      chk_flush = 5'((1 << fs0) - 1);
    end else chk_cyc = -1;
    seen_exc = 1'b0;
    epc_due = 1'b0;
    wr_cnt = 0;
    mon_on = 1'b1;
    for (int c = 0; c < 16; c++) begin
      cyc = c;
      if_valid_i = (c < n);
      if_pc_i = base + 32'(4 * c);
      if_cause_i = '0; id_cause_i = '0; ex_cause_i = '0; mem_cause_i = '0;
      br_flush_i = (c == brc);
      if (fi0 >= 0 && c == fi0 + fs0) begin
        case (fs0) 0: if_cause_i = 4'(fc0); 1: id_cause_i = 4'(fc0);
                   2: ex_cause_i = 4'(fc0); default: mem_cause_i = 4'(fc0); endcase
      end
      if (fi1 >= 0 && c == fi1 + fs1) begin
        case (fs1) 0: if_cause_i = 4'(fc1); 1: id_cause_i = 4'(fc1);
                   2: ex_cause_i = 4'(fc1); default: mem_cause_i = 4'(fc1); endcase
      end
      @(posedge clk); #1;
    end
    mon_on = 1'b0;
    check(exp_q.size() == 0, {"R6 ", tag}, "missing retirements", exp_q.size(), 0);
    check(seen_exc == exp_exc, {"R7 ", tag}, "exception taken", seen_exc, exp_exc);
    check(wr_cnt == n_commit(n, j, brc), {"R6 ", tag}, "memory writes", wr_cnt,
          n_commit(n, j, brc));
    exp_q.delete();
  endtask

  function automatic int n_commit(input int n, input int j, input int brc);
    int cnt = 0;
    for (int i = 0; i < n; i++)
      if (!(brc >= 0 && (i == brc || i == brc - 1)) && (j < 0 || i < j)) cnt++;
    return cnt;
  endfunction

  initial begin
    #(200000 * 5);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stall_front_o == 0, "R1", "stall", stall_front_o, 0);
    check(redirect_o == 0, "R1", "redirect", redirect_o, 0);
    check(wb_commit_o == 0, "R1", "retire", wb_commit_o, 0);
    check(flush_o == 0, "R1", "flush", flush_o, 0);
    check(epc_o == 0, "R1", "epc", epc_o, 0);
    check(ecause_o == 0, "R1", "cause", ecause_o, 0);
    @(posedge clk); #1;

    // R2 clean flow
    run_scn(1, 5, -1, 0, 0, -1, 0, 0, -1, "R2");
    // R5 overflow in execute on the third instruction
    run_scn(2, 5, 2, 2, 5, -1, 0, 0, -1, "R5");
    // R8 fetch page fault on the first instruction, nothing to drain
    run_scn(3, 5, 0, 0, 1, -1, 0, 0, -1, "R8");
    // R3 illegal opcode kept over a later data page fault
    run_scn(4, 5, 1, 1, 3, 1, 3, 7, -1, "R3");
    // R4 same-cycle faults: memory-stage older beats decode-stage younger
    run_scn(5, 5, 1, 3, 8, 3, 1, 4, -1, "R4");
    // R10 younger fetch fault first, older protection fault a cycle later
    run_scn(6, 5, 3, 0, 2, 1, 3, 9, -1, "R10");
    // R9 mispredict discards a wrong-path decode fault
    run_scn(7, 5, 2, 1, 3, -1, 0, 0, 3, "R9");
    // R6 divide by zero on the last of five, four older retire first
    run_scn(8, 5, 4, 2, 6, -1, 0, 0, -1, "R6");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule